// File: doc/BRIEF.md
# Multiplexed Keypad Scan Register

This block is a single byte-wide register on a simple processor bus that lets software read seven buttons through one byte, a group at a time. Software writes group-select bits into the upper nibble. A read returns that upper nibble as written. The lower nibble holds the button levels of the group picked by the highest set select bit.

A rotate input changes which buttons each group reports, and on which bits, so that the device can be held on its side. The button levels arrive already debounced but asynchronous. They and the rotate input each pass through a two-flop synchroniser before they are used. The read port is registered: the byte appears on the cycle after the read strobe and is zero on all other cycles.

Top module: `keypad_scan_reg`

## Requirements
- R1: After reset the stored upper nibble is 0, rotated mode is off, and a read of the register returns 8'h00.
- R2: A write to `REG_ADDR` stores `wr_data_i[7:4]`, and later reads return those four bits on `rd_data_o[7:4]`. A write to any other address leaves the stored nibble unchanged.
- R3: The select bits have a fixed priority: bit 6 over bit 5 over bit 4. Only the highest set select bit decides the lower nibble. Bit 7 is stored but selects nothing.
- R4: Normal mode, bit 6 set: the lower nibble reads {B, A, start, 0}, with B on bit 3, A on bit 2, start on bit 1 and bit 0 at 0.
- R5: Normal mode, bit 6 clear and bit 5 set: the lower nibble reads {left, down, right, up}, with up on bit 0, right on bit 1, down on bit 2 and left on bit 3.
- R6: Normal mode, bit 4 as the only set select bit: the lower nibble reads 0. In either mode, with no select bit set, the lower nibble reads 0.
- R7: Rotated mode, bit 6 set: only start is reported, on bit 1. Bits 0, 2 and 3 read 0.
- R8: Rotated mode, bit 6 clear and bit 5 set: A reads on bit 0 and B on bit 2. Bits 1 and 3 read 0.
- R9: Rotated mode, bit 4 as the only set select bit: left reads on bit 0, up on bit 1, right on bit 2 and down on bit 3.
- R10: A read strobe to `REG_ADDR` puts the byte on `rd_data_o` in the following cycle. On every other cycle, including after a read of another address, `rd_data_o` is 8'h00.
- R11: Buttons are active high. A change of a button or of the rotate input that is first sampled at clock edge E0 is ignored by read strobes taken at E0 and E1. It shows in a read strobe taken at E0+2.
- R12: If a write and a read to `REG_ADDR` happen in the same cycle, the read returns the upper nibble stored before that write. The next read returns the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_start_i | input | 1 | Start button level, active high |
| btn_a_i | input | 1 | Button A level, active high |
| btn_b_i | input | 1 | Button B level, active high |
| btn_up_i | input | 1 | Up button level, active high |
| btn_right_i | input | 1 | Right button level, active high |
| btn_down_i | input | 1 | Down button level, active high |
| btn_left_i | input | 1 | Left button level, active high |
| rotate_i | input | 1 | Sideways orientation flag, active high |
| addr_i | input | ADDR_W | Bus address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data, zero when no read is returned |

## Verification
The bench drives inputs on the falling edge and samples on the falling edge that follows the capturing rising edge. A register read therefore shows its byte one rising edge after the strobe. A write shows in any read issued from the next cycle on. A button or rotate change needs two rising edges of synchronisation, so a read taken on the third edge is the first to show it. The bench waits three edges after every input change before it reads. One scenario holds the read strobe high across the change and checks the old, old, new sequence. Another issues a write and a read in the same cycle to show that the read sees the value stored before the write.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int SEL_LSB = 4;
    localparam int NUM_BTN = 7;

    typedef struct packed {
        logic start;
        logic a;
        logic b;
        logic up;
        logic right;
        logic down;
        logic left;
    } kp_btn_t;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_LOW   = 2'd1,
        GRP_DIR   = 2'd2,
        GRP_SYS   = 2'd3
    } kp_grp_e;

    function automatic kp_grp_e kp_decode(input logic [2:0] sel);
        kp_grp_e g;
        if (sel[2])      g = GRP_SYS;
        else if (sel[1]) g = GRP_DIR;
        else if (sel[0]) g = GRP_LOW;
        else             g = GRP_NONE;
        return g;
    endfunction

    function automatic logic [NIB_W-1:0] kp_pack_upright(input kp_grp_e g,
                                                         input kp_btn_t b);
        logic [NIB_W-1:0] n;
        case (g)
            GRP_SYS: n = {b.b, b.a, b.start, 1'b0};
            GRP_DIR: n = {b.left, b.down, b.right, b.up};
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic logic [NIB_W-1:0] kp_pack_sideways(input kp_grp_e g,
                                                          input kp_btn_t b);
        logic [NIB_W-1:0] n;
        case (g)
            GRP_SYS: n = {1'b0, 1'b0, b.start, 1'b0};
            GRP_DIR: n = {1'b0, b.b, 1'b0, b.a};
            GRP_LOW: n = {b.down, b.right, b.up, b.left};
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kp_sel_reg.sv
module kp_sel_reg
    import kp_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [NIB_W-1:0]  sel_o
);
    logic hit;
    assign hit = wr_en_i && (addr_i == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)      sel_o <= '0;
        else if (hit) sel_o <= wr_data_i[SEL_LSB +: NIB_W];
    end
endmodule

// File: rtl/kp_nibble_mux.sv
module kp_nibble_mux
    import kp_pkg::*;
(
    input  logic [NIB_W-1:0] sel_i,
    input  logic             rotate_i,
    input  kp_btn_t          btn_i,
    output logic [NIB_W-1:0] nib_o
);
    kp_grp_e          grp;
    logic [NIB_W-1:0] nib_up;
    logic [NIB_W-1:0] nib_side;

    always_comb begin
        grp      = kp_decode(sel_i[2:0]);
        nib_up   = kp_pack_upright(grp, btn_i);
        nib_side = kp_pack_sideways(grp, btn_i);
        nib_o    = rotate_i ? nib_side : nib_up;
    end
endmodule

// File: rtl/keypad_scan_reg.sv
module keypad_scan_reg
    import kp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h35,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_start_i,
    input  logic              btn_a_i,
    input  logic              btn_b_i,
    input  logic              btn_up_i,
    input  logic              btn_right_i,
    input  logic              btn_down_i,
    input  logic              btn_left_i,
    input  logic              rotate_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o
);
    localparam int RAW_W = NUM_BTN + 1;

    kp_btn_t          btn_raw;
    kp_btn_t          btn_s;
    logic             rot_s;
    logic [RAW_W-1:0] raw_vec;
    logic [RAW_W-1:0] sync_vec;
    logic [NIB_W-1:0] sel_q;
    logic [NIB_W-1:0] nib;
    logic             rd_hit;

    always_comb begin
        btn_raw.start = btn_start_i;
        btn_raw.a     = btn_a_i;
        btn_raw.b     = btn_b_i;
        btn_raw.up    = btn_up_i;
        btn_raw.right = btn_right_i;
        btn_raw.down  = btn_down_i;
        btn_raw.left  = btn_left_i;
    end

    assign raw_vec = {rotate_i, btn_raw};

    kp_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_vec),
        .q_o (sync_vec)
    );

    assign btn_s = kp_btn_t'(sync_vec[NUM_BTN-1:0]);
    assign rot_s = sync_vec[RAW_W-1];

    kp_sel_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .sel_o     (sel_q)
    );

    kp_nibble_mux u_mux (
        .sel_i    (sel_q),
        .rotate_i (rot_s),
        .btn_i    (btn_s),
        .nib_o    (nib)
    );

    assign rd_hit = rd_en_i && (addr_i == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)         rd_data_o <= '0;
        else if (rd_hit) rd_data_o <= {sel_q, nib};
        else             rd_data_o <= '0;
    end
endmodule

// File: rtl/keypad_scan_reg_chk.sv
module keypad_scan_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h35
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_en_i,
    input logic [7:0]        rd_data_o,
    input logic [3:0]        sel_q,
    input logic              rot_s
);
    logic rd_hit;
    assign rd_hit = rd_en_i && (addr_i == REG_ADDR);

    a_r2_upper_echo: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> rd_data_o[7:4] == $past(sel_q));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> rd_data_o == 8'h00);

    a_r6_no_select: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && sel_q[2:0] == 3'b000) |=> rd_data_o[3:0] == 4'h0);

    a_r6_low_only_upright: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !rot_s && sel_q[2:0] == 3'b001) |=> rd_data_o[3:0] == 4'h0);

    a_r4_bit0_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !rot_s && sel_q[2]) |=> !rd_data_o[0]);

    a_r7_start_only: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && rot_s && sel_q[2]) |=> (rd_data_o[3:0] & 4'b1101) == 4'h0);

    a_r8_ab_only: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && rot_s && sel_q[2:1] == 2'b01) |=> (rd_data_o[3:0] & 4'b1010) == 4'h0);
endmodule

bind keypad_scan_reg keypad_scan_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .sel_q     (sel_q),
    .rot_s     (rot_s)
);

// File: tb/keypad_scan_reg_tb.sv
module keypad_scan_reg_tb;
    localparam logic [7:0] RA = 8'h35;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] btn = '0;   // {left, down, right, up, b, a, start}
    logic       rot = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    keypad_scan_reg u_dut (
        .clk         (clk),
        .rst         (rst),
        .btn_start_i (btn[0]),
        .btn_a_i     (btn[1]),
        .btn_b_i     (btn[2]),
        .btn_up_i    (btn[3]),
        .btn_right_i (btn[4]),
        .btn_down_i  (btn[5]),
        .btn_left_i  (btn[6]),
        .rotate_i    (rot),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_data)
    );

    // Expected lower nibble, written from R3..R9.
    function automatic logic [3:0] exp_nib(input logic [3:0] up, input logic r,
                                           input logic [6:0] b);
        logic st, ba, bb, u, rt, dn, lf;
        {lf, dn, rt, u, bb, ba, st} = b;
        if (!r) begin
            if (up[2])      return {bb, ba, st, 1'b0};
            else if (up[1]) return {lf, dn, rt, u};
            else            return 4'h0;
        end else begin
            if (up[2])      return {2'b00, st, 1'b0};
            else if (up[1]) return {1'b0, bb, 1'b0, ba};
            else if (up[0]) return {dn, rt, u, lf};
            else            return 4'h0;
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_inputs(input logic [6:0] b, input logic r);
        @(negedge clk);
        btn = b;
        rot = r;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(rd_data == 8'h00, "R1 idle after reset", rd_data, 8'h00);
        do_read(RA, d);
        check(d == 8'h00, "R1 reset read", d, 8'h00);
    endtask

    task automatic t_groups(input logic r, input string tag);
        logic [7:0] d;
        logic [6:0] pats [5] = '{7'h55, 7'h2A, 7'h7F, 7'h01, 7'h48};
        logic [7:0] sels [4] = '{8'h40, 8'h20, 8'h10, 8'h00};
        foreach (pats[p]) begin
            set_inputs(pats[p], r);
            foreach (sels[s]) begin
                logic [7:0] e;
                do_write(RA, sels[s]);
                do_read(RA, d);
                e = {sels[s][7:4], exp_nib(sels[s][7:4], r, pats[p])};
                check(d == e, tag, d, e);
            end
        end
    endtask

    task automatic t_priority();
        logic [7:0] d;
        set_inputs(7'h7F, 1'b0);
        do_write(RA, 8'h70);
        do_read(RA, d);
        check(d == 8'h7E, "R3 bit6 wins over 5 and 4", d, 8'h7E);
        do_write(RA, 8'h30);
        do_read(RA, d);
        check(d == 8'h3F, "R3 bit5 wins over 4", d, 8'h3F);
        do_write(RA, 8'hC0);
        do_read(RA, d);
        check(d == 8'hCE, "R3 bit7 selects nothing", d, 8'hCE);
        set_inputs(7'h7F, 1'b1);
        do_write(RA, 8'h30);
        do_read(RA, d);
        check(d == 8'h35, "R3 rotated bit5 wins over 4", d, 8'h35);
    endtask

    task automatic t_upper();
        logic [7:0] d;
        set_inputs(7'h00, 1'b0);
        do_write(RA, 8'hA5);
        do_read(RA, d);
        check(d == 8'hA0, "R2 upper echo", d, 8'hA0);
        do_write(RA + 8'h01, 8'hF0);
        do_read(RA, d);
        check(d == 8'hA0, "R2 other address write ignored", d, 8'hA0);
    endtask

    task automatic t_read_port();
        logic [7:0] d;
        set_inputs(7'h7F, 1'b0);
        do_write(RA, 8'h40);
        do_read(RA - 8'h01, d);
        check(d == 8'h00, "R10 other address reads zero", d, 8'h00);
        do_read(RA, d);
        check(d == 8'h4E, "R10 read returned next cycle", d, 8'h4E);
        @(negedge clk);
        check(rd_data == 8'h00, "R10 zero after read cycle", rd_data, 8'h00);
    endtask

    task automatic t_latency();
        logic [7:0] exp [3] = '{8'h20, 8'h20, 8'h21};
        set_inputs(7'h00, 1'b0);
        do_write(RA, 8'h20);
        @(negedge clk);
        btn = 7'h08;
        addr = RA;
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(rd_data == exp[i], "R11 button sync latency", rd_data, exp[i]);
        end
        rd_en = 1'b0;
        // rotate change: sel bit4 only, left pressed
        set_inputs(7'h40, 1'b0);
        do_write(RA, 8'h10);
        @(negedge clk);
        rot = 1'b1;
        rd_en = 1'b1;
        exp = '{8'h10, 8'h10, 8'h11};
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(rd_data == exp[i], "R11 rotate sync latency", rd_data, exp[i]);
        end
        rd_en = 1'b0;
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        set_inputs(7'h00, 1'b0);
        do_write(RA, 8'h40);
        @(negedge clk);
        addr = RA; wr_data = 8'h20; wr_en = 1'b1; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_data == 8'h40, "R12 read sees old value", rd_data, 8'h40);
        do_read(RA, d);
        check(d == 8'h20, "R12 next read sees new value", d, 8'h20);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_groups(1'b0, "R4 R5 R6 upright groups");
        t_groups(1'b1, "R7 R8 R9 R6 rotated groups");
        t_priority();
        t_upper();
        t_read_port();
        t_latency();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule